// File: doc/BRIEF.md
# Serial Memory-Display Line Receiver

This block is the panel end of a three-wire serial display link, clocked by the serial clock itself. While chip select is high, each rising clock edge takes one bit from the data line. A frame has a fixed layout. Three mode flags come first, then five pad bits. A 7-bit row address follows, least-significant bit first, with one pad bit after it. Then come 96 pixel bits and 16 transfer clocks that carry no data.

Writing happens in two stages. The pixel bits shift into a line latch, and the latch is copied into a 96x96 one-bit frame memory only on the last of the 16 transfer clocks. A copy of a whole row is available on a read port at any time. A common-electrode level output follows either the polarity flag of the frame or an external level input. Which one it follows depends on a mode pin.

Dropping chip select restarts the bit count and clears the update flag and the clear flag. A frame cut short before its final transfer clock therefore leaves memory unchanged. The clear flag erases the whole frame memory in one cycle.

Top module: `memlcd_rx`

## Requirements
- R1: After reset, every row read through `rd_row` returns all zeros, and `vcom` is low while `ext_mode` is low.
- R2: Frame bit positions are counted from 0 at the first clock edge with `cs` high. Bit 0 is the update flag, bit 1 the polarity flag and bit 2 the clear flag. Bits 3..7 and bit 15 are ignored. Bits 8..14 carry the row address, least-significant first. Bits 16..111 are pixel data, and pixel bit k (k = 0..95, in arrival order) lands in `rd_line[k]`.
- R3: When the update flag is 1 and the address is below 96, the latched line is written to the addressed row on the clock edge of bit 127 (the 16th transfer clock). From then on it is visible on `rd_line`.
- R4: When the update flag is 0, a complete frame leaves every row unchanged.
- R5: When `cs` falls before bit 127 has been clocked, the row write is abandoned and memory is unchanged.
- R6: A frame whose address is 96 or above writes no row.
- R7: With `ext_mode` low, `vcom` takes the polarity flag from the edge of bit 1 onward. It holds that value across deselect. With `ext_mode` high, `vcom` equals `ext_vcom`, whatever the polarity flag was.
- R8: A clock edge with `cs` low clears the update and clear flags and restarts the bit count at 0. A clear flag of 1 followed by deselect before bit 3 erases nothing.
- R9: A clear flag of 1 with `cs` still high on the edge of bit 3 sets every row to zero on that edge. If the update flag is also 1, the row write at bit 127 still follows.
- R10: A `rd_row` value of 96 or above reads all zeros.
- R11: Clock edges after bit 127 with `cs` still high have no effect until the next deselect.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| sdi | input | 1 | Serial data |
| ext_mode | input | 1 | 1: `vcom` follows `ext_vcom`; 0: follows polarity flag |
| ext_vcom | input | 1 | External common-electrode level |
| rd_row | input | 7 | Row selected on the read port |
| rd_line | output | 96 | Contents of the selected row, bit k = pixel k |
| vcom | output | 1 | Common-electrode level |

## Verification
The read port is combinational over the frame memory. A row write therefore shows on `rd_line` right after the rising edge of bit 127, and an all-clear shows right after the edge of bit 3. `vcom` changes right after the edge of bit 1, and the two-stage reset synchroniser adds two cycles after reset release. The bench drives `cs` and `sdi` on falling edges and lowers `cs` only after the last bit it intends to send. It then reads rows back after deselect, one nanosecond after changing `rd_row`, so every result it samples is already settled. The frame lengths it uses (3, 4, 127, 128 and 148 bits) sit exactly on either side of the clear edge and the commit edge.

// File: rtl/memlcd_pkg.sv
package memlcd_pkg;
  localparam int unsigned LINE_PIX   = 96;
  localparam int unsigned LINE_COUNT = 96;
  localparam int unsigned ROW_ADDR_W = 7;
  localparam int unsigned MODE_LEN   = 3;
  localparam int unsigned MODE_PAD   = 5;
  localparam int unsigned ADDR_PAD   = 1;
  localparam int unsigned XFER_LEN   = 16;

  typedef struct packed {
    logic upd;
    logic pol;
    logic clr;
  } mode_flags_t;
endpackage

// File: rtl/memlcd_bitcnt.sv
module memlcd_bitcnt #(
  parameter int unsigned TOTAL = 128,
  parameter int unsigned CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = CW'(TOTAL);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!cs)
      cnt_d = '0;
    else if (cnt_q != FULL)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/memlcd_decode.sv
module memlcd_decode
  import memlcd_pkg::*;
#(
  parameter int unsigned PIX    = 96,
  parameter int unsigned AW     = 7,
  parameter int unsigned MLEN   = 3,
  parameter int unsigned MPAD   = 5,
  parameter int unsigned APAD   = 1,
  parameter int unsigned CW     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           sdi,
  input  logic [CW-1:0]  cnt,
  output mode_flags_t    flags,
  output logic [AW-1:0]  row_addr,
  output logic [PIX-1:0] line
);
  localparam int unsigned ADDR_START = MLEN + MPAD;
  localparam int unsigned DATA_START = ADDR_START + AW + APAD;
  localparam logic [CW-1:0] POS_UPD = CW'(0);
  localparam logic [CW-1:0] POS_POL = CW'(1);
  localparam logic [CW-1:0] POS_CLR = CW'(2);

  mode_flags_t    flags_q, flags_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [PIX-1:0] line_q, line_d;

  always_comb begin
    flags_d = flags_q;
    if (!cs) begin
      flags_d.upd = 1'b0;
      flags_d.clr = 1'b0;
    end else begin
      if (cnt == POS_UPD) flags_d.upd = sdi;
      if (cnt == POS_POL) flags_d.pol = sdi;
      if (cnt == POS_CLR) flags_d.clr = sdi;
    end
  end

  for (genvar g = 0; g < AW; g++) begin : g_addr
    localparam logic [CW-1:0] POS = CW'(ADDR_START + g);
    assign addr_d[g] = (cs && cnt == POS) ? sdi : addr_q[g];
  end

  for (genvar g = 0; g < PIX; g++) begin : g_line
    localparam logic [CW-1:0] POS = CW'(DATA_START + g);
    assign line_d[g] = (cs && cnt == POS) ? sdi : line_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      addr_q  <= '0;
      line_q  <= '0;
    end else begin
      flags_q <= flags_d;
      addr_q  <= addr_d;
      line_q  <= line_d;
    end
  end

  assign flags    = flags_q;
  assign row_addr = addr_q;
  assign line     = line_q;
endmodule

// File: rtl/memlcd_framemem.sv
module memlcd_framemem #(
  parameter int unsigned PIX  = 96,
  parameter int unsigned ROWS = 96,
  parameter int unsigned AW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           clr,
  input  logic [AW-1:0]  wr_row,
  input  logic [PIX-1:0] wr_line,
  input  logic [AW-1:0]  rd_row,
  output logic [PIX-1:0] rd_line
);
  logic [PIX-1:0] mem_q [ROWS];
  logic [PIX-1:0] mem_d [ROWS];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      mem_d[r] = mem_q[r];
      if (clr)
        mem_d[r] = '0;
      if (we && wr_row == AW'(r))
        mem_d[r] = wr_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we || clr) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= mem_d[r];
    end
  end

  always_comb begin
    rd_line = '0;
    for (int r = 0; r < ROWS; r++)
      if (rd_row == AW'(r)) rd_line = mem_q[r];
  end
endmodule

// File: rtl/memlcd_rx.sv
module memlcd_rx
  import memlcd_pkg::*;
#(
  parameter int unsigned PIX   = LINE_PIX,
  parameter int unsigned ROWS  = LINE_COUNT,
  parameter int unsigned AW    = ROW_ADDR_W,
  parameter int unsigned MLEN  = MODE_LEN,
  parameter int unsigned MPAD  = MODE_PAD,
  parameter int unsigned APAD  = ADDR_PAD,
  parameter int unsigned XLEN  = XFER_LEN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs,
  input  logic           sdi,
  input  logic           ext_mode,
  input  logic           ext_vcom,
  input  logic [AW-1:0]  rd_row,
  output logic [PIX-1:0] rd_line,
  output logic           vcom
);
  localparam int unsigned TOTAL = MLEN + MPAD + AW + APAD + PIX + XLEN;
  localparam int unsigned CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(TOTAL - 1);
  localparam logic [CW-1:0] CLR_BIT  = CW'(MLEN);
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  logic [1:0]     rst_sync_q;
  logic           rst_n_sync;
  logic [CW-1:0]  cnt;
  mode_flags_t    flags;
  logic [AW-1:0]  row_addr;
  logic [PIX-1:0] line;
  logic           mem_we, mem_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  memlcd_bitcnt #(.TOTAL(TOTAL), .CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n_sync), .cs(cs), .cnt(cnt)
  );

  memlcd_decode #(
    .PIX(PIX), .AW(AW), .MLEN(MLEN), .MPAD(MPAD), .APAD(APAD), .CW(CW)
  ) dec_i (
    .clk(clk), .rst_n(rst_n_sync), .cs(cs), .sdi(sdi), .cnt(cnt),
    .flags(flags), .row_addr(row_addr), .line(line)
  );

  assign mem_we  = cs && flags.upd && (cnt == LAST_BIT) && (row_addr <= LAST_ROW);
  assign mem_clr = cs && flags.clr && (cnt == CLR_BIT);

  memlcd_framemem #(.PIX(PIX), .ROWS(ROWS), .AW(AW)) mem_i (
    .clk(clk), .rst_n(rst_n_sync), .we(mem_we), .clr(mem_clr),
    .wr_row(row_addr), .wr_line(line), .rd_row(rd_row), .rd_line(rd_line)
  );

  assign vcom = ext_mode ? ext_vcom : flags.pol;
endmodule

// File: rtl/memlcd_rx_chk.sv
module memlcd_rx_chk #(
  parameter int unsigned PIX  = 96,
  parameter int unsigned ROWS = 96,
  parameter int unsigned AW   = 7,
  parameter int unsigned CW   = 8,
  parameter int unsigned LAST = 127
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs,
  input logic           sdi,
  input logic [CW-1:0]  cnt,
  input logic           upd,
  input logic           clr,
  input logic           mem_we,
  input logic           mem_clr,
  input logic [AW-1:0]  row_addr,
  input logic [AW-1:0]  rd_row,
  input logic [PIX-1:0] rd_line,
  input logic           ext_mode,
  input logic           ext_vcom,
  input logic           vcom
);
  localparam logic [CW-1:0] LAST_BIT = CW'(LAST);
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);
  localparam logic [CW-1:0] POL_BIT  = CW'(1);

  // R8
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (!upd && !clr));

  // R3
  commit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cs && upd && cnt == LAST_BIT));

  // R6
  commit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (row_addr <= LAST_ROW));

  // R9
  clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr |=> (rd_line == '0));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !mem_clr) |=> (!$stable(rd_row) || $stable(rd_line)));

  // R7
  vcom_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (vcom == ext_vcom));

  // R7
  vcom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && cs && cnt == POL_BIT) |=> (ext_mode || vcom == $past(sdi)));
endmodule

bind memlcd_rx memlcd_rx_chk #(
  .PIX(PIX), .ROWS(ROWS), .AW(AW), .CW(CW), .LAST(TOTAL - 1)
) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .cs(cs), .sdi(sdi), .cnt(cnt),
  .upd(flags.upd), .clr(flags.clr), .mem_we(mem_we), .mem_clr(mem_clr),
  .row_addr(row_addr), .rd_row(rd_row), .rd_line(rd_line),
  .ext_mode(ext_mode), .ext_vcom(ext_vcom), .vcom(vcom)
);

// File: tb/memlcd_rx_tb_top.sv
`timescale 1ns/1ps
module memlcd_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, cs, sdi, ext_mode, ext_vcom;
  logic [6:0]  rd_row;
  logic [95:0] rd_line;
  logic        vcom;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [95:0] exp_mem [96];

  always #2.5 clk = ~clk;

  memlcd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .ext_mode(ext_mode),
    .ext_vcom(ext_vcom), .rd_row(rd_row), .rd_line(rd_line), .vcom(vcom)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [95:0] act,
                       input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] pat(input int r, input int s);
    logic [31:0] w;
    w = (32'(r) + 32'd1) * 32'h9E3779B1 ^ 32'(s);
    return {w ^ 32'h5555AAAA, ~w, w};
  endfunction

  function automatic logic [127:0] frame(input bit upd, input bit pol, input bit clr,
                                         input logic [6:0] addr, input logic [95:0] d);
    logic [127:0] f;
    f = '0;
    f[0] = upd; f[1] = pol; f[2] = clr;
    f[7:3] = 5'b10101;
    for (int i = 0; i < 7; i++) f[8+i] = addr[i];
    f[15] = 1'b1;
    for (int i = 0; i < 96; i++) f[16+i] = d[i];
    f[127:112] = 16'hA5C3;
    return f;
  endfunction

  task automatic send(input logic [127:0] f, input int nbits);
    @(negedge clk);
    cs = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 128) ? f[i] : 1'(i % 3);
      @(negedge clk);
    end
    cs = 1'b0;
    sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < 96; r++) begin
      rd_row = 7'(r);
      #1;
      check(rd_line === exp_mem[r], tag, rd_line, exp_mem[r]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; sdi = 1'b0; ext_mode = 1'b0; ext_vcom = 1'b0;
    rd_row = '0;
    for (int r = 0; r < 96; r++) exp_mem[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_all("R1 reset row");
    check(vcom === 1'b0, "R1 reset vcom", 96'(vcom), 96'd0);

    // R2 R3 sweep over every row with full frames
    for (int r = 0; r < 96; r++) begin
      exp_mem[r] = pat(r, 7);
      send(frame(1'b1, 1'b0, 1'b0, 7'(r), exp_mem[r]), 128);
    end
    check_all("R3 row write");
    rd_row = 7'd5; #1;
    check(rd_line[0] === pat(5, 7)[0], "R2 first pixel bit0", 96'(rd_line[0]), 96'(pat(5, 7)[0]));

    // R4 display-mode frame keeps memory
    send(frame(1'b0, 1'b0, 1'b0, 7'd10, ~pat(10, 7)), 128);
    check_all("R4 display mode");

    // R5 abort one clock short, then complete frame
    send(frame(1'b1, 1'b0, 1'b0, 7'd20, 96'hF0F0), 127);
    check_all("R5 aborted write");
    exp_mem[20] = pat(20, 99);
    send(frame(1'b1, 1'b0, 1'b0, 7'd20, exp_mem[20]), 128);
    check_all("R5 R8 restart after abort");

    // R6 out-of-range addresses
    send(frame(1'b1, 1'b0, 1'b0, 7'd96, ~pat(0, 1)), 128);
    send(frame(1'b1, 1'b0, 1'b0, 7'd127, ~pat(0, 2)), 128);
    check_all("R6 bad address");

    // R11 extra clocks after commit ignored
    exp_mem[33] = pat(33, 55);
    send(frame(1'b1, 1'b0, 1'b0, 7'd33, exp_mem[33]), 148);
    check_all("R11 trailing clocks");

    // R10 read beyond last row
    rd_row = 7'd96; #1;
    check(rd_line === '0, "R10 read row 96", rd_line, '0);
    rd_row = 7'd127; #1;
    check(rd_line === '0, "R10 read row 127", rd_line, '0);

    // R7 polarity and external level
    send(frame(1'b0, 1'b1, 1'b0, 7'd0, '0), 128);
    check(vcom === 1'b1, "R7 vcom from flag", 96'(vcom), 96'd1);
    ext_mode = 1'b1; ext_vcom = 1'b0; #1;
    check(vcom === 1'b0, "R7 vcom external low", 96'(vcom), 96'd0);
    ext_vcom = 1'b1; #1;
    check(vcom === 1'b1, "R7 vcom external high", 96'(vcom), 96'd1);
    send(frame(1'b0, 1'b0, 1'b0, 7'd0, '0), 128);
    ext_vcom = 1'b1; #1;
    check(vcom === 1'b1, "R7 flag ignored in ext mode", 96'(vcom), 96'd1);
    ext_mode = 1'b0; #1;
    check(vcom === 1'b0, "R7 vcom back to flag", 96'(vcom), 96'd0);

    // R8 clear flag dropped by deselect before bit 3
    send(frame(1'b0, 1'b0, 1'b1, 7'd0, '0), 3);
    check_all("R8 clear cancelled");

    // R9 clear executes when bit 3 is clocked
    send(frame(1'b0, 1'b0, 1'b1, 7'd0, '0), 4);
    for (int r = 0; r < 96; r++) exp_mem[r] = '0;
    check_all("R9 all clear");

    // R9 clear plus update in one frame
    for (int r = 0; r < 96; r++) begin
      exp_mem[r] = pat(r, 3);
      send(frame(1'b1, 1'b0, 1'b0, 7'(r), exp_mem[r]), 128);
    end
    send(frame(1'b1, 1'b0, 1'b1, 7'd42, pat(42, 77)), 128);
    for (int r = 0; r < 96; r++) exp_mem[r] = '0;
    exp_mem[42] = pat(42, 77);
    check_all("R9 clear then write");

    finish_run();
  end
endmodule